// File: doc/BRIEF.md
# Eye Monitor Raster Scan Controller

This block is the digital sequencer inside an on-chip eye-opening monitor for a high-speed serial receiver. After a start pulse it walks a two-dimensional grid. A phase-interpolator code sets the sampling instant across the unit interval. A reference-DAC code sets the decision threshold. At every grid point the block watches a one-bit comparator result over a fixed run of clock cycles. It counts the cycles in which the input was above the threshold and stores that count as a small intensity value in an internal pixel memory.

When the scan finishes, a host reads the pixel memory through a simple synchronous read port and turns the intensities into a coloured eye diagram. The default grid is 64 phase positions by 60 threshold levels. Each pixel is observed for 8 cycles, so one full eye takes 30720 sampling cycles, which is 76.8 µs at 400 MHz.

Top module: `eye_scan_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are low, both code outputs are zero, and every read of the pixel memory returns zero until a scan has completed.
- R2: A `start` pulse sampled while idle raises `busy` in the next cycle. That cycle presents phase code 0 and threshold code 0.
- R3: Threshold code is the inner loop, counting 0 to 59 and never reaching 60..63. Phase code is the outer loop, counting 0 to 63 and advancing by one each time the threshold code wraps from 59 to 0.
- R4: Number the first busy cycle 0. The codes of pixel k are presented in cycles 8k to 8k+7, and the comparator is sampled for that pixel in cycles 8k+1 to 8k+8. The codes therefore settle for one cycle before the window opens, and consecutive windows overlap the next code change by one cycle.
- R5: A pixel's stored value is a 4-bit unsigned count, 0 to 8, of the window cycles in which `comp_in` was 1. The order of the ones inside the window does not matter.
- R6: The value of the pixel at phase p and threshold level l is stored at read address p*60 + l.
- R7: `busy` stays high for exactly 30721 cycles. In the cycle where `busy` first reads low, `done` is high for that single cycle. Both codes are back at zero once the last window has opened.
- R8: While idle, a read address sampled at a clock edge yields its pixel value on `rd_data` after that edge. While busy, `rd_data` is zero. An address of 3840 or above reads as zero.
- R9: A `start` pulse during a scan is ignored. The code sequence and the end of the scan are unchanged.
- R10: A new scan replaces every stored pixel, so values from an earlier scan do not survive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a full eye scan |
| comp_in | input | 1 | Comparator decision, 1 when the input exceeds the threshold |
| rd_addr | input | 12 | Pixel read address, phase*60 + level |
| pi_code | output | 6 | Phase-interpolator control word |
| dac_code | output | 6 | Threshold-DAC control word |
| busy | output | 1 | High while a scan is in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| rd_data | output | 4 | Registered pixel intensity read back |

## Verification
Counting the start edge as cycle 0, the codes of pixel k must be visible throughout cycles 8k to 8k+7. The bench drives the comparator value of cycle n at the falling edge inside that cycle and checks the codes at the falling edges of cycles 8k and 8k+7. `busy` must still be high in cycle 30720, and `done` must be high with `busy` low in cycle 30721. Read data appears one clock after the address is applied. The bench therefore sets the address at a falling edge and samples at the next falling edge. Expected intensities come from the comparator pattern the bench itself generated for each window.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;

  localparam int unsigned EYE_N_PHASE  = 64;
  localparam int unsigned EYE_N_LEVEL  = 60;
  localparam int unsigned EYE_N_SAMPLE = 8;
  localparam int unsigned EYE_PI_W     = 6;
  localparam int unsigned EYE_DAC_W    = 6;
  localparam int unsigned EYE_PIX_W    = 4;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/eye_scan_rst_sync.sv
module eye_scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sn = hold_q;

endmodule

// File: rtl/eye_scan_seq.sv
module eye_scan_seq
  import eye_scan_pkg::*;
#(
  parameter  int unsigned N_PHASE  = EYE_N_PHASE,
  parameter  int unsigned N_LEVEL  = EYE_N_LEVEL,
  parameter  int unsigned N_SAMPLE = EYE_N_SAMPLE,
  parameter  int unsigned PI_W     = EYE_PI_W,
  parameter  int unsigned DAC_W    = EYE_DAC_W,
  parameter  int unsigned ADDR_W   = $clog2(N_PHASE * N_LEVEL),
  localparam int unsigned SLOT_W   = $clog2(N_SAMPLE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [PI_W-1:0]   pi_code,
  output logic [DAC_W-1:0]  dac_code,
  output logic              run,
  output logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SAMPLE - 1);
  localparam logic [PI_W-1:0]   PH_LAST   = PI_W'(N_PHASE - 1);
  localparam logic [DAC_W-1:0]  LV_LAST   = DAC_W'(N_LEVEL - 1);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q,  slot_d;
  logic [PI_W-1:0]   phase_q, phase_d;
  logic [DAC_W-1:0]  level_q, level_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic              grid_last;
  logic              seq_en;

  assign grid_last = (phase_q == PH_LAST) && (level_q == LV_LAST);
  assign seq_en    = start || (state_q == SEQ_RUN);

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    phase_d = phase_q;
    level_d = level_q;
    addr_d  = addr_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_RUN;
          slot_d  = '0;
          phase_d = '0;
          level_d = '0;
          addr_d  = '0;
        end
      end
      SEQ_RUN: begin
        if (slot_q == SLOT_LAST) begin
          slot_d = '0;
          if (grid_last) begin
            state_d = SEQ_IDLE;
            phase_d = '0;
            level_d = '0;
            addr_d  = '0;
          end else begin
            addr_d = addr_q + 1'b1;
            if (level_q == LV_LAST) begin
              level_d = '0;
              phase_d = phase_q + 1'b1;
            end else begin
              level_d = level_q + 1'b1;
            end
          end
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      slot_q  <= '0;
      phase_q <= '0;
      level_q <= '0;
      addr_q  <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      slot_q  <= slot_d;
      phase_q <= phase_d;
      level_q <= level_d;
      addr_q  <= addr_d;
    end
  end

  assign pi_code  = phase_q;
  assign dac_code = level_q;
  assign run      = (state_q == SEQ_RUN);
  assign slot     = slot_q;
  assign addr     = addr_q;
  assign last     = grid_last;

endmodule

// File: rtl/eye_scan_accum.sv
module eye_scan_accum
  import eye_scan_pkg::*;
#(
  parameter  int unsigned N_SAMPLE = EYE_N_SAMPLE,
  parameter  int unsigned PIX_W    = EYE_PIX_W,
  parameter  int unsigned ADDR_W   = 12,
  localparam int unsigned SLOT_W   = $clog2(N_SAMPLE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SLOT_W-1:0] slot,
  input  logic [ADDR_W-1:0] addr,
  input  logic              last,
  input  logic              comp,
  output logic              tag_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data,
  output logic              scan_end
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SAMPLE - 1);

  // Tag stage: the sequencer's view one cycle late, aligned with the window.
  logic              tv_q;
  logic [SLOT_W-1:0] ts_q;
  logic [ADDR_W-1:0] ta_q;
  logic              tl_q;
  logic [PIX_W-1:0]  acc_q, acc_d;
  logic [PIX_W-1:0]  acc_base;
  logic              tag_en;

  assign tag_en   = run || tv_q;
  assign acc_base = (ts_q == '0) ? '0 : acc_q;
  assign acc_d    = acc_base + PIX_W'(comp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q <= 1'b0;
      ts_q <= '0;
      ta_q <= '0;
      tl_q <= 1'b0;
    end else if (tag_en) begin
      tv_q <= run;
      ts_q <= slot;
      ta_q <= addr;
      tl_q <= last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (tv_q) begin
      acc_q <= acc_d;
    end
  end

  assign tag_valid = tv_q;
  assign wr_en     = tv_q && (ts_q == SLOT_LAST);
  assign wr_addr   = ta_q;
  assign wr_data   = acc_d;
  assign scan_end  = wr_en && tl_q;

endmodule

// File: rtl/eye_scan_store.sv
module eye_scan_store
  import eye_scan_pkg::*;
#(
  parameter int unsigned N_PIX  = EYE_N_PHASE * EYE_N_LEVEL,
  parameter int unsigned PIX_W  = EYE_PIX_W,
  parameter int unsigned ADDR_W = $clog2(N_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fill,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PIX_W-1:0]  rd_data
);

  localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(N_PIX);

  logic [PIX_W-1:0] mem [N_PIX];
  logic             valid_q, valid_d;
  logic             rd_ok;
  logic [PIX_W-1:0] rd_q, rd_d;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (clear) begin
      valid_d = 1'b0;
    end else if (fill) begin
      valid_d = 1'b1;
    end
  end

  assign rd_ok = valid_q && !busy && (rd_addr < ADDR_END);
  assign rd_d  = rd_ok ? mem[rd_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rd_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rd_q    <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl
  import eye_scan_pkg::*;
#(
  parameter  int unsigned N_PHASE  = EYE_N_PHASE,
  parameter  int unsigned N_LEVEL  = EYE_N_LEVEL,
  parameter  int unsigned N_SAMPLE = EYE_N_SAMPLE,
  parameter  int unsigned PI_W     = EYE_PI_W,
  parameter  int unsigned DAC_W    = EYE_DAC_W,
  parameter  int unsigned PIX_W    = EYE_PIX_W,
  localparam int unsigned N_PIX    = N_PHASE * N_LEVEL,
  localparam int unsigned ADDR_W   = $clog2(N_PIX),
  localparam int unsigned SLOT_W   = $clog2(N_SAMPLE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              comp_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PI_W-1:0]   pi_code,
  output logic [DAC_W-1:0]  dac_code,
  output logic              busy,
  output logic              done,
  output logic [PIX_W-1:0]  rd_data
);

  logic              rst_sn;
  logic              start_ok;
  logic              run;
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] seq_addr;
  logic              seq_last;
  logic              tag_valid;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [PIX_W-1:0]  wr_data;
  logic              scan_end;
  logic              done_q;

  eye_scan_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign busy     = run || tag_valid;
  assign start_ok = start && !busy;

  eye_scan_seq #(
    .N_PHASE  (N_PHASE),
    .N_LEVEL  (N_LEVEL),
    .N_SAMPLE (N_SAMPLE),
    .PI_W     (PI_W),
    .DAC_W    (DAC_W),
    .ADDR_W   (ADDR_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start    (start_ok),
    .pi_code  (pi_code),
    .dac_code (dac_code),
    .run      (run),
    .slot     (slot),
    .addr     (seq_addr),
    .last     (seq_last)
  );

  eye_scan_accum #(
    .N_SAMPLE (N_SAMPLE),
    .PIX_W    (PIX_W),
    .ADDR_W   (ADDR_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_sn),
    .run       (run),
    .slot      (slot),
    .addr      (seq_addr),
    .last      (seq_last),
    .comp      (comp_in),
    .tag_valid (tag_valid),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .scan_end  (scan_end)
  );

  eye_scan_store #(
    .N_PIX  (N_PIX),
    .PIX_W  (PIX_W),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clear   (start_ok),
    .fill    (scan_end),
    .busy    (busy),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      done_q <= 1'b0;
    end else begin
      done_q <= scan_end;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/eye_scan_chk.sv
module eye_scan_chk #(
  parameter int unsigned N_LEVEL = 60,
  parameter int unsigned PI_W    = 6,
  parameter int unsigned DAC_W   = 6,
  parameter int unsigned PIX_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [PI_W-1:0]  pi_code,
  input logic [DAC_W-1:0] dac_code,
  input logic [PIX_W-1:0] rd_data
);

  AST_DAC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(dac_code) < N_LEVEL); // R3

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (dac_code != $past(dac_code)))
      |-> ((32'(dac_code) == 32'($past(dac_code)) + 1) || (dac_code == '0))); // R3

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (pi_code != $past(pi_code)))
      |-> ((dac_code == '0) &&
           ((32'(pi_code) == 32'($past(pi_code)) + 1) || (pi_code == '0)))); // R3

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7

  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rd_data == '0)); // R8

endmodule

bind eye_scan_ctrl eye_scan_chk #(
  .N_LEVEL (N_LEVEL),
  .PI_W    (PI_W),
  .DAC_W   (DAC_W),
  .PIX_W   (PIX_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sn),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pi_code  (pi_code),
  .dac_code (dac_code),
  .rd_data  (rd_data)
);

// File: tb/eye_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module eye_scan_ctrl_tb_top;

  localparam int NPH   = 64;
  localparam int NLV   = 60;
  localparam int NSMP  = 8;
  localparam int NPIX  = NPH * NLV;
  localparam int SCANC = NPIX * NSMP;

  // Read-back grid points: {phase[11:6], level[5:0]}
  localparam logic [11:0] PTS [16] = '{
    {6'd0,  6'd0 }, {6'd0,  6'd1 }, {6'd0,  6'd7 }, {6'd0,  6'd59},
    {6'd1,  6'd0 }, {6'd1,  6'd59}, {6'd2,  6'd30}, {6'd10, 6'd17},
    {6'd31, 6'd44}, {6'd32, 6'd0 }, {6'd47, 6'd58}, {6'd62, 6'd59},
    {6'd63, 6'd0 }, {6'd63, 6'd1 }, {6'd63, 6'd58}, {6'd63, 6'd59}
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        comp_in;
  logic [11:0] rd_addr;
  logic [5:0]  pi_code;
  logic [5:0]  dac_code;
  logic        busy;
  logic        done;
  logic [3:0]  rd_data;

  int checks = 0;
  int fails  = 0;

  eye_scan_ctrl dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .comp_in  (comp_in),
    .rd_addr  (rd_addr),
    .pi_code  (pi_code),
    .dac_code (dac_code),
    .busy     (busy),
    .done     (done),
    .rd_data  (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_pix(input int k, input int seed);
    return (k * 5 + seed) % 9;
  endfunction

  // Comparator value driven in busy cycle n (cycle 0 = start edge).
  function automatic logic comp_of(input int n, input int seed);
    int k;
    int j;
    if (n < 1 || n > SCANC) return 1'b0;
    k = (n - 1) / NSMP;
    j = (n - 1) % NSMP;
    return (((j * 3 + k) % NSMP) < exp_pix(k, seed));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic read_pix(input int addr, output int val);
    rd_addr = addr[11:0];
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic run_scan(input int seed, input int poke_n);
    start = 1'b1;
    @(posedge clk);
    for (int n = 0; n <= SCANC + 2; n++) begin
      @(negedge clk);
      start   = (n == poke_n);
      comp_in = comp_of(n, seed);
      if (n == 0) begin
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        check(pi_code == 6'd0 && dac_code == 6'd0, "R2", "first codes",
              int'({pi_code, dac_code}), 0);
      end
      if (n < SCANC && (n % NSMP == 0 || n % NSMP == 7)) begin
        int k;
        int ep;
        int el;
        k  = n / NSMP;
        ep = k / NLV;
        el = k % NLV;
        if (n % NSMP == 0)
          check(int'(pi_code) == ep && int'(dac_code) == el, "R4",
                "codes at window lead", int'(pi_code) * 64 + int'(dac_code), ep * 64 + el);
        else
          check(int'(pi_code) == ep && int'(dac_code) == el, "R3",
                "codes at window tail", int'(pi_code) * 64 + int'(dac_code), ep * 64 + el);
      end
      if (n == 200)
        check(rd_data == 4'd0, "R8", "read during scan", int'(rd_data), 0);
      if (n == SCANC)
        check(busy && !done, "R7", "last busy cycle", int'({busy, done}), 2);
      if (n == SCANC + 1) begin
        check(!busy && done, "R7", "done cycle", int'({busy, done}), 1);
        check(pi_code == 6'd0 && dac_code == 6'd0, "R7", "codes parked",
              int'({pi_code, dac_code}), 0);
      end
      if (n == SCANC + 2)
        check(!done, "R7", "done single pulse", int'(done), 0);
    end
  endtask

  task automatic sweep_table(input int seed, input string req);
    int v;
    for (int i = 0; i < 16; i++) begin
      int p;
      int l;
      p = int'(PTS[i][11:6]);
      l = int'(PTS[i][5:0]);
      read_pix(p * NLV + l, v);
      check(v == exp_pix(p * NLV + l, seed), req, "pixel value R5 R6", v,
            exp_pix(p * NLV + l, seed));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int v;
    rst_n   = 1'b0;
    start   = 1'b0;
    comp_in = 1'b0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(!busy && !done, "R1", "flags after reset", int'({busy, done}), 0);
    check(pi_code == 6'd0 && dac_code == 6'd0, "R1", "codes after reset",
          int'({pi_code, dac_code}), 0);
    read_pix(0, v);
    check(v == 0, "R1", "read before scan addr 0", v, 0);
    read_pix(NPIX - 1, v);
    check(v == 0, "R1", "read before scan last addr", v, 0);

    // First scan, no spurious start
    run_scan(0, -10);
    sweep_table(0, "R5");
    read_pix(4000, v);
    check(v == 0, "R8", "out-of-range address", v, 0);
    read_pix(7, v);
    check(v == 8, "R5", "full-count pixel", v, 8);
    read_pix(0, v);
    check(v == 0, "R5", "empty pixel", v, 0);
    read_pix(1 * NLV + 0, v);
    check(v == exp_pix(60, 0), "R6", "phase 1 level 0 address", v, exp_pix(60, 0));

    // Second scan, different pattern, start pulse mid-scan (R9)
    run_scan(4, 5000);
    sweep_table(4, "R10");
    read_pix(0, v);
    check(v == 4, "R10", "pixel 0 rewritten", v, 4);
    read_pix(NPIX - 1, v);
    check(v == exp_pix(NPIX - 1, 4), "R9", "last pixel after ignored start", v,
          exp_pix(NPIX - 1, 4));
    check(!busy, "R9", "no restart after ignored start", int'(busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule